// File: doc/BRIEF.md
# Power and Fault Shutdown Sequencer

This block decides the operating state of an audio amplifier's control logic. It watches a digital supply good flag, a digitised power-stage supply level, an active-low shutdown pin, a software shutdown bit and six fault condition flags. From these it drives the register reset, the core regulator enable, the analog power-down, a one-cycle volume ramp request and a latched fault vector. It also reports its current state as a one-hot vector.

Faults fall into three groups. A digital supply dip drops the block straight into reset, and that reset clears the configuration. A power-stage under-voltage while playing, or any fault of the internal regulator, parks the block in a fault shutdown that it never leaves by itself. Software has to request shutdown, or the pin has to be pulled, before the block can leave. Over-temperature, over-current and clock errors are recoverable. They move the block into software shutdown, and once every such condition is gone it returns to playback with a ramp request.

The shutdown pin and the fault flags pass through a two-stage synchroniser. The supply flag, the supply code and the software bit are synchronous and are used directly. Every output is a register loaded from the next-state decode, so each output changes on the same edge as the state.

Top module: `pwr_fault_seq`

## Requirements
- R1: After `rst`, or while in the reset state, `state_oh` = 7'b0000001, `reg_rst`=1, `core_reg_en`=0, `ana_pd`=1, `ramp_req`=0 and `fault_lat`=0.
- R2: When `dvdd_ok` is sampled low at a clock edge in any state, that same edge enters the reset state and clears `fault_lat`.
- R3: With `dvdd_ok` high, reset moves to hardware shutdown (`state_oh` bit 1). The block stays there while `sdn_pin` is low. A rising `sdn_pin` enters regulator power-up (bit 2) on the third edge, and `core_reg_en` goes to 1 on that same edge.
- R4: Regulator power-up lasts REG_WAIT cycles and mode detection (bit 3) lasts MODE_WAIT cycles. The block then enters active (bit 5). It enters software shutdown (bit 4) instead if `sw_sd` is set, if `pvdd_code` < `pvdd_thresh` (unsigned), or if a recoverable fault is present.
- R5: `ana_pd` is 0 only in the active state. If `pvdd_code` < `pvdd_thresh` while active, the next edge enters fault shutdown (bit 6) and sets `fault_lat[0]`.
- R6: Over-temperature, over-current and clock error (`fault_lat` bits 1, 2, 3) move the active state to software shutdown on the third edge after the flag rises. When all three are clear, `sw_sd`=0 and the supply code is valid, the block returns to active. `ramp_req` is then high for exactly the one cycle in which the block re-enters active, and only when the shutdown was caused by such a fault.
- R7: A regulator under-voltage, over-voltage or overload flag (`flt_ldo` bits 0, 1, 2, latched in `fault_lat` bits 4, 5, 6) moves the active or software shutdown state to fault shutdown. The block stays in fault shutdown after the flag clears, until `sw_sd` or the pin takes it out.
- R8: Latched bits survive recovery. They clear only in hardware shutdown, in reset, or on entering or staying in software shutdown while `sw_sd`=1.
- R9: `sw_sd`=1 in active enters software shutdown on the next edge. Clearing it returns the block to active with no `ramp_req`.
- R10: `sdn_pin` low, seen through the synchroniser, enters hardware shutdown from any non-reset state on the third edge and drops `core_reg_en`.
- R11: `state_oh` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dvdd_ok | input | 1 | Digital supply valid flag |
| pvdd_code | input | PVDD_W | Digitised power-stage supply level |
| pvdd_thresh | input | PVDD_W | Programmable power-stage under-voltage threshold |
| sdn_pin | input | 1 | Shutdown pin, low requests hardware shutdown (asynchronous) |
| sw_sd | input | 1 | Software shutdown request |
| flt_ot | input | 1 | Over-temperature condition (asynchronous) |
| flt_oc | input | 1 | Over-current condition (asynchronous) |
| flt_clk | input | 1 | Audio clock error condition (asynchronous) |
| flt_ldo | input | 3 | Regulator faults: bit 0 under-voltage, bit 1 over-voltage, bit 2 overload (asynchronous) |
| reg_rst | output | 1 | Configuration register reset |
| core_reg_en | output | 1 | Core regulator enable |
| ana_pd | output | 1 | Analog core power-down |
| ramp_req | output | 1 | One-cycle volume ramp-up request |
| fault_lat | output | 7 | Latched faults: 0 supply, 1 temperature, 2 current, 3 clock, 4-6 regulator |
| state_oh | output | 7 | One-hot state: 0 reset, 1 hw shutdown, 2 reg power-up, 3 mode detect, 4 sw shutdown, 5 active, 6 fault shutdown |

## Verification
The synchronous inputs (`dvdd_ok`, `sw_sd`, `pvdd_code`) act on the first edge after they change. The pin and the fault flags act on the third edge, because the two synchroniser flops come before the state register. All outputs are registered together with the state. The bench drives on falling edges and samples on falling edges. The directed tests count edges exactly, checking the cycle before a change, the change itself and the cycle after. The table rows wait several cycles past the longest latency before they compare. `ramp_req` is sampled on every falling edge of a row, so the bench can prove it pulsed exactly once.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int NUM_ST  = 7;
  localparam int NUM_FLT = 6;
  localparam int NUM_LAT = NUM_FLT + 1;

  localparam int I_RESET = 0;
  localparam int I_HWSD  = 1;
  localparam int I_REGUP = 2;
  localparam int I_MODE  = 3;
  localparam int I_SWSD  = 4;
  localparam int I_ACT   = 5;
  localparam int I_FLTSD = 6;

  // synchronised fault vector positions; latch bit = position + 1
  localparam int F_OT  = 0;
  localparam int F_OC  = 1;
  localparam int F_CLK = 2;
  localparam int F_RUV = 3;
  localparam int F_ROV = 4;
  localparam int F_ROL = 5;

  typedef enum logic [NUM_ST-1:0] {
    ST_RESET = 7'b0000001,
    ST_HWSD  = 7'b0000010,
    ST_REGUP = 7'b0000100,
    ST_MODE  = 7'b0001000,
    ST_SWSD  = 7'b0010000,
    ST_ACT   = 7'b0100000,
    ST_FLTSD = 7'b1000000
  } seq_state_t;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_fault_latch.sv
module pfs_fault_latch #(
  parameter int NF = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [NF-1:0] flt_s,
  input  logic        set_en,
  input  logic        pvdd_evt,
  input  logic        clr,
  output logic [NF:0] lat
);
  logic [NF:0] src;

  assign src = {flt_s & {NF{set_en}}, pvdd_evt};

  always_ff @(posedge clk) begin
    if (rst || clr) lat <= '0;
    else            lat <= lat | src;
  end
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
#(
  parameter int REG_WAIT  = 4,
  parameter int MODE_WAIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dvdd_ok,
  input  logic       sd_rel,
  input  logic       sw_sd,
  input  logic       pvdd_low,
  input  logic       rec_any,
  input  logic       reg_any,
  output seq_state_t state,
  output seq_state_t nxt,
  output logic       reg_rst,
  output logic       core_reg_en,
  output logic       ana_pd,
  output logic       ramp_req
);
  localparam int MAXW = (REG_WAIT > MODE_WAIT) ? REG_WAIT : MODE_WAIT;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] REG_LAST  = CW'(REG_WAIT - 1);
  localparam logic [CW-1:0] MODE_LAST = CW'(MODE_WAIT - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          rec_flag, rec_nxt, ramp_nxt;

  always_comb begin
    nxt = state;
    if (!dvdd_ok) begin
      nxt = ST_RESET;
    end else if (state != ST_RESET && !sd_rel) begin
      nxt = ST_HWSD;
    end else begin
      case (state)
        ST_RESET: nxt = ST_HWSD;
        ST_HWSD:  nxt = ST_REGUP;
        ST_REGUP: if (cnt == REG_LAST) nxt = ST_MODE;
        ST_MODE:  if (cnt == MODE_LAST)
                    nxt = (sw_sd || pvdd_low || rec_any) ? ST_SWSD : ST_ACT;
        ST_ACT: begin
          if (reg_any || pvdd_low)   nxt = ST_FLTSD;
          else if (rec_any || sw_sd) nxt = ST_SWSD;
        end
        ST_SWSD: begin
          if (reg_any)                               nxt = ST_FLTSD;
          else if (!sw_sd && !rec_any && !pvdd_low)  nxt = ST_ACT;
        end
        ST_FLTSD: if (sw_sd) nxt = ST_SWSD;
        default:  nxt = ST_RESET;
      endcase
    end
  end

  always_comb begin
    if (nxt != state)
      cnt_nxt = '0;
    else if (state == ST_REGUP || state == ST_MODE)
      cnt_nxt = cnt + 1'b1;
    else
      cnt_nxt = cnt;
  end

  assign rec_nxt  = (state == ST_ACT  && nxt == ST_SWSD && rec_any) ||
                    (state == ST_SWSD && nxt == ST_SWSD && rec_flag && !sw_sd);
  assign ramp_nxt = (state == ST_SWSD) && (nxt == ST_ACT) && rec_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RESET;
      cnt         <= '0;
      rec_flag    <= 1'b0;
      reg_rst     <= 1'b1;
      core_reg_en <= 1'b0;
      ana_pd      <= 1'b1;
      ramp_req    <= 1'b0;
    end else begin
      state       <= nxt;
      cnt         <= cnt_nxt;
      rec_flag    <= rec_nxt;
      reg_rst     <= (nxt == ST_RESET);
      core_reg_en <= (nxt != ST_RESET) && (nxt != ST_HWSD);
      ana_pd      <= (nxt != ST_ACT);
      ramp_req    <= ramp_nxt;
    end
  end
endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq
  import pfs_pkg::*;
#(
  parameter int PVDD_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int REG_WAIT    = 4,
  parameter int MODE_WAIT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dvdd_ok,
  input  logic [PVDD_W-1:0] pvdd_code,
  input  logic [PVDD_W-1:0] pvdd_thresh,
  input  logic              sdn_pin,
  input  logic              sw_sd,
  input  logic              flt_ot,
  input  logic              flt_oc,
  input  logic              flt_clk,
  input  logic [2:0]        flt_ldo,
  output logic              reg_rst,
  output logic              core_reg_en,
  output logic              ana_pd,
  output logic              ramp_req,
  output logic [NUM_LAT-1:0] fault_lat,
  output logic [NUM_ST-1:0]  state_oh
);
  localparam int SYNC_W = NUM_FLT + 1;

  logic [SYNC_W-1:0]  raw_in, sync_out;
  logic [NUM_FLT-1:0] flt_s;
  logic               sd_rel, pvdd_low, rec_any, reg_any;
  logic               set_en, pvdd_evt, lat_clr;
  seq_state_t         state, nxt;

  assign raw_in   = {flt_ldo, flt_clk, flt_oc, flt_ot, sdn_pin};
  assign sd_rel   = sync_out[0];
  assign flt_s    = sync_out[SYNC_W-1:1];
  assign pvdd_low = (pvdd_code < pvdd_thresh);
  assign rec_any  = flt_s[F_OT] | flt_s[F_OC] | flt_s[F_CLK];
  assign reg_any  = flt_s[F_RUV] | flt_s[F_ROV] | flt_s[F_ROL];

  pfs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  pfs_fsm #(.REG_WAIT(REG_WAIT), .MODE_WAIT(MODE_WAIT)) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .dvdd_ok     (dvdd_ok),
    .sd_rel      (sd_rel),
    .sw_sd       (sw_sd),
    .pvdd_low    (pvdd_low),
    .rec_any     (rec_any),
    .reg_any     (reg_any),
    .state       (state),
    .nxt         (nxt),
    .reg_rst     (reg_rst),
    .core_reg_en (core_reg_en),
    .ana_pd      (ana_pd),
    .ramp_req    (ramp_req)
  );

  assign set_en   = (state != ST_RESET) && (state != ST_HWSD);
  assign pvdd_evt = (state == ST_ACT) && pvdd_low;
  assign lat_clr  = (nxt == ST_RESET) || (nxt == ST_HWSD) ||
                    ((nxt == ST_SWSD) && sw_sd);

  pfs_fault_latch #(.NF(NUM_FLT)) i_lat (
    .clk      (clk),
    .rst      (rst),
    .flt_s    (flt_s),
    .set_en   (set_en),
    .pvdd_evt (pvdd_evt),
    .clr      (lat_clr),
    .lat      (fault_lat)
  );

  assign state_oh = state;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
  import pfs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              dvdd_ok,
  input logic              sw_sd,
  input logic [NUM_ST-1:0] state_oh,
  input logic              reg_rst,
  input logic              core_reg_en,
  input logic              ana_pd,
  input logic              ramp_req
);
  a_r11_one_state: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);

  a_r1_reset_outputs: assert property (@(posedge clk) disable iff (rst)
    state_oh[I_RESET] |-> (reg_rst && !core_reg_en && ana_pd && !ramp_req));

  a_r2_supply_drop: assert property (@(posedge clk) disable iff (rst)
    !dvdd_ok |=> state_oh[I_RESET]);

  a_r5_pd_only_active: assert property (@(posedge clk) disable iff (rst)
    !ana_pd |-> state_oh[I_ACT]);

  a_r6_ramp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ramp_req |=> !ramp_req);

  a_r6_ramp_on_return: assert property (@(posedge clk) disable iff (rst)
    ramp_req |-> (state_oh[I_ACT] && $past(state_oh[I_SWSD])));

  a_r7_no_retry: assert property (@(posedge clk) disable iff (rst)
    (state_oh[I_FLTSD] && !sw_sd) |=> !state_oh[I_ACT]);

  a_r9_sw_leaves_active: assert property (@(posedge clk) disable iff (rst)
    (state_oh[I_ACT] && sw_sd) |=> !state_oh[I_ACT]);

  a_r10_hw_reg_off: assert property (@(posedge clk) disable iff (rst)
    state_oh[I_HWSD] |-> !core_reg_en);
endmodule

bind pwr_fault_seq pfs_checker i_chk (
  .clk         (clk),
  .rst         (rst),
  .dvdd_ok     (dvdd_ok),
  .sw_sd       (sw_sd),
  .state_oh    (state_oh),
  .reg_rst     (reg_rst),
  .core_reg_en (core_reg_en),
  .ana_pd      (ana_pd),
  .ramp_req    (ramp_req)
);

// File: tb/test_pwr_fault_seq.sv
module test_pwr_fault_seq;
  import pfs_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dvdd_ok = 1'b0;
  logic [5:0] pvdd_code = 6'd30;
  logic [5:0] pvdd_thresh = 6'd20;
  logic       sdn_pin = 1'b0;
  logic       sw_sd = 1'b0;
  logic [5:0] flt = '0;   // {ldo_ol, ldo_ov, ldo_uv, clk, oc, ot}
  logic       reg_rst, core_reg_en, ana_pd, ramp_req;
  logic [6:0] fault_lat, state_oh;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_fault_seq i_pwr_fault_seq (
    .clk(clk), .rst(rst), .dvdd_ok(dvdd_ok), .pvdd_code(pvdd_code),
    .pvdd_thresh(pvdd_thresh), .sdn_pin(sdn_pin), .sw_sd(sw_sd),
    .flt_ot(flt[0]), .flt_oc(flt[1]), .flt_clk(flt[2]), .flt_ldo(flt[5:3]),
    .reg_rst(reg_rst), .core_reg_en(core_reg_en), .ana_pd(ana_pd),
    .ramp_req(ramp_req), .fault_lat(fault_lat), .state_oh(state_oh)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       dv;
    logic       sdn;
    logic       sw;
    logic [5:0] code;
    logic [5:0] flt;
    logic [7:0] wcyc;
    logic [2:0] st;
    logic [6:0] lat;
    logic [1:0] ramps;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0,1'b0,1'b0,6'd30,6'b000000,8'd4, 3'd0,7'b0000000,2'd0}, // R1 hold in reset
    '{4'd3,  1'b1,1'b0,1'b0,6'd30,6'b000000,8'd4, 3'd1,7'b0000000,2'd0}, // R3 hw shutdown
    '{4'd4,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd12,3'd5,7'b0000000,2'd0}, // R4 power-up to active
    '{4'd6,  1'b1,1'b1,1'b0,6'd30,6'b000001,8'd6, 3'd4,7'b0000010,2'd0}, // R6 over-temp
    '{4'd6,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd6, 3'd5,7'b0000010,2'd1}, // R6 R8 recover, ramp
    '{4'd9,  1'b1,1'b1,1'b1,6'd30,6'b000000,8'd3, 3'd4,7'b0000000,2'd0}, // R9 R8 sw shutdown clears
    '{4'd9,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd3, 3'd5,7'b0000000,2'd0}, // R9 no ramp
    '{4'd5,  1'b1,1'b1,1'b0,6'd10,6'b000000,8'd3, 3'd6,7'b0000001,2'd0}, // R5 supply low
    '{4'd7,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd5, 3'd6,7'b0000001,2'd0}, // R7 sticky
    '{4'd8,  1'b1,1'b1,1'b1,6'd30,6'b000000,8'd3, 3'd4,7'b0000000,2'd0}, // R8 sw clears
    '{4'd9,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd3, 3'd5,7'b0000000,2'd0}, // R9
    '{4'd7,  1'b1,1'b1,1'b0,6'd30,6'b010000,8'd6, 3'd6,7'b0100000,2'd0}, // R7 regulator ov
    '{4'd7,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd6, 3'd6,7'b0100000,2'd0}, // R7 no retry
    '{4'd10, 1'b1,1'b0,1'b0,6'd30,6'b000000,8'd6, 3'd1,7'b0000000,2'd0}, // R10 pin
    '{4'd4,  1'b1,1'b1,1'b0,6'd30,6'b000100,8'd14,3'd4,7'b0001000,2'd0}, // R4 clock fault at mode
    '{4'd6,  1'b1,1'b1,1'b0,6'd30,6'b000000,8'd6, 3'd5,7'b0001000,2'd0}, // R6 no ramp from mode
    '{4'd6,  1'b1,1'b1,1'b0,6'd30,6'b000010,8'd6, 3'd4,7'b0001100,2'd0}, // R6 over-current
    '{4'd2,  1'b0,1'b1,1'b0,6'd30,6'b000010,8'd2, 3'd0,7'b0000000,2'd0}  // R2 supply dip
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state_oh", state_oh, 7'b0000001);
    chk("R1 reset reg_rst", reg_rst, 1);
    chk("R1 reset core_reg_en", core_reg_en, 0);
    chk("R1 reset ana_pd", ana_pd, 1);
    chk("R1 reset ramp_req", ramp_req, 0);
    chk("R1 reset fault_lat", fault_lat, 0);

    for (int i = 0; i < NV; i++) begin
      int rc;
      vec_t v;
      v = VECS[i];
      dvdd_ok = v.dv; sdn_pin = v.sdn; sw_sd = v.sw;
      pvdd_code = v.code; flt = v.flt;
      rc = 0;
      for (int k = 0; k < int'(v.wcyc); k++) begin
        @(posedge clk);
        @(negedge clk);
        if (ramp_req) rc++;
      end
      chk($sformatf("R%0d row%0d state", v.req, i), state_oh, 7'b1 << v.st);
      chk($sformatf("R%0d row%0d fault_lat", v.req, i), fault_lat, v.lat);
      chk($sformatf("R6 row%0d ramp count", i), rc, v.ramps);
      chk($sformatf("R1 row%0d reg_rst", i), reg_rst, v.st == 3'(I_RESET));
      chk($sformatf("R3 row%0d core_reg_en", i), core_reg_en,
          (v.st != 3'(I_RESET)) && (v.st != 3'(I_HWSD)));
      chk($sformatf("R5 row%0d ana_pd", i), ana_pd, v.st != 3'(I_ACT));
      chk($sformatf("R11 row%0d onehot", i), $countones(state_oh), 1);
    end

    // R3 R4: exact power-up timing
    flt = '0; dvdd_ok = 1'b1; sdn_pin = 1'b0; sw_sd = 1'b0; pvdd_code = 6'd30;
    tick(5);
    chk("R3 hw before release", state_oh, 7'b0000010);
    sdn_pin = 1'b1;
    tick(2);
    chk("R3 still hw at edge 2", state_oh, 7'b0000010);
    tick(1);
    chk("R3 reg power-up at edge 3", state_oh, 7'b0000100);
    chk("R3 core_reg_en at edge 3", core_reg_en, 1);
    tick(3);
    chk("R4 still reg power-up", state_oh, 7'b0000100);
    tick(1);
    chk("R4 mode detect after REG_WAIT", state_oh, 7'b0001000);
    tick(1);
    chk("R4 still mode detect", state_oh, 7'b0001000);
    tick(1);
    chk("R4 active after MODE_WAIT", state_oh, 7'b0100000);
    chk("R5 ana_pd low in active", ana_pd, 0);

    // R6: ramp pulse timing
    flt = 6'b000001;
    tick(5);
    chk("R6 sw shutdown on temp", state_oh, 7'b0010000);
    flt = '0;
    tick(2);
    chk("R6 no ramp at edge 2", ramp_req, 0);
    chk("R6 still shutdown at edge 2", state_oh, 7'b0010000);
    tick(1);
    chk("R6 ramp at edge 3", ramp_req, 1);
    chk("R6 active at edge 3", state_oh, 7'b0100000);
    tick(1);
    chk("R6 ramp gone at edge 4", ramp_req, 0);

    // R2: one-edge supply dip response
    dvdd_ok = 1'b0;
    tick(1);
    chk("R2 reset after one edge", state_oh, 7'b0000001);
    chk("R2 reg_rst after one edge", reg_rst, 1);
    dvdd_ok = 1'b1;
    tick(1);
    chk("R3 hw after supply returns", state_oh, 7'b0000010);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule